// File: doc/BRIEF.md
# Predicated SIMD Write-Back Masker

This block sits at the write-back edge of a SIMD execution pipe, in front of a register file whose write port takes one enable line per byte. Each cycle it accepts a result word, an element-width code, a predicate with one bit per element, an inversion flag taken from the opcode, and a mode bit. From these it forms the bytes to write and the per-byte write enables. The destination register is never read. Masked-out elements are either left untouched, by holding their byte enables low, or overwritten with zero.

The predicate can be inverted by the opcode bit before it is used, so software does not need a separate instruction that complements the mask. Each predicate bit is widened to cover all the bytes of its element for the selected element width. Predicate bits beyond the element count of that width play no part. Both outputs are registered, with one cycle of latency, and are cleared by a synchronous active-high reset.

Top module: `wb_pred_masker`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `wr_data_o` and `byte_we_o` become all zeros on that edge.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: When `pred_inv_i` is 1, every predicate bit is complemented before any other use. When it is 0, the predicate is used as given.
- R4: With `width_sel_i` = 00 (8-bit elements), predicate bit b governs byte b (bits 8b+7..8b) of the word.
- R5: With `width_sel_i` = 01, 10 or 11 (16, 32 or 64-bit elements), predicate bit i governs every byte of element i. Element i occupies bytes i*2^code through i*2^code + 2^code - 1, counted from the least significant byte.
- R6: Predicate bits at positions at or above the element count of the selected width (8, 4, 2, 1 elements) have no effect on either output.
- R7: In non-zeroing mode (`zero_mode_i` = 0) with `wr_valid_i` = 1, byte b is enabled exactly when its element is active after inversion, and `wr_data_o` equals `data_i` unchanged.
- R8: In zeroing mode (`zero_mode_i` = 1) with `wr_valid_i` = 1, all byte enables are 1. Bytes of active elements carry `data_i`, and bytes of inactive elements are 0x00.
- R9: When `wr_valid_i` = 0, `byte_we_o` is all zeros, regardless of mode, width, predicate and inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | A write-back is present this cycle |
| data_i | input | 64 | Result word from the SIMD unit |
| width_sel_i | input | 2 | Element width: 00=8, 01=16, 10=32, 11=64 bits |
| pred_i | input | 8 | Predicate, bit i for element i |
| pred_inv_i | input | 1 | Opcode bit that complements the predicate |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = non-zeroing (merge) |
| wr_data_o | output | 64 | Data for the register file write port |
| byte_we_o | output | 8 | Per-byte write enables |

## Verification
The bench builds the block with its default 64-bit word, which gives eight byte lanes and therefore all four element-width codes. At that width the 64-bit code collapses to a single element, so the ignored-bits rule can be seen in its most extreme form: seven of the eight predicate bits are dead. A width of 64 also makes 8-bit elements line up one-to-one with the predicate, so inversion can be checked bit by bit against the enables.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

   localparam int unsigned WSEL_W = 2;

   typedef enum logic [WSEL_W-1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } elem_w_e;

   localparam int unsigned NUM_WCODES = 2 ** WSEL_W;

endpackage

// File: rtl/pred_condition.sv
module pred_condition #(
   parameter int unsigned PRED_W = 8
) (
   input  logic [PRED_W-1:0] pred_raw,
   input  logic              invert,
   output logic [PRED_W-1:0] pred_eff
);

   for (genvar i = 0; i < PRED_W; i++) begin : g_bit
      assign pred_eff[i] = pred_raw[i] ^ invert;
   end

endmodule

// File: rtl/pred_expand.sv
module pred_expand
   import wbm_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8
) (
   input  elem_w_e              width,
   input  logic [NUM_BYTES-1:0] pred_eff,
   output logic [NUM_BYTES-1:0] byte_act
);

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic [NUM_WCODES-1:0] cand;
      for (genvar c = 0; c < NUM_WCODES; c++) begin : g_code
         localparam int unsigned ELEM_IDX = b >> c;
         assign cand[c] = pred_eff[ELEM_IDX];
      end
      assign byte_act[b] = cand[width];
   end

endmodule

// File: rtl/lane_gate.sv
module lane_gate #(
   parameter int unsigned NUM_BYTES = 8,
   localparam int unsigned DATA_W = NUM_BYTES * 8
) (
   input  logic                 valid,
   input  logic                 zero_mode,
   input  logic [NUM_BYTES-1:0] byte_act,
   input  logic [DATA_W-1:0]    data_in,
   output logic [DATA_W-1:0]    data_out,
   output logic [NUM_BYTES-1:0] we_out
);

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      logic clear_byte;
      assign clear_byte = zero_mode & ~byte_act[b];
      assign data_out[b*8 +: 8] = clear_byte ? 8'h00 : data_in[b*8 +: 8];
      assign we_out[b] = valid & (zero_mode | byte_act[b]);
   end

endmodule

// File: rtl/wb_pred_masker.sv
module wb_pred_masker
   import wbm_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned NUM_BYTES = DATA_W / 8,
   localparam int unsigned PRED_W = NUM_BYTES
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_valid_i,
   input  logic [DATA_W-1:0]    data_i,
   input  logic [WSEL_W-1:0]    width_sel_i,
   input  logic [PRED_W-1:0]    pred_i,
   input  logic                 pred_inv_i,
   input  logic                 zero_mode_i,
   output logic [DATA_W-1:0]    wr_data_o,
   output logic [NUM_BYTES-1:0] byte_we_o
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("wb_pred_masker: DATA_W must be a whole number of bytes");
   end
   if ((NUM_BYTES & (NUM_BYTES - 1)) != 0 || NUM_BYTES == 0) begin : g_bad_lanes
      $error("wb_pred_masker: byte lane count must be a power of two");
   end

   elem_w_e              wsel;
   logic [PRED_W-1:0]    pred_eff;
   logic [NUM_BYTES-1:0] byte_act;
   logic [DATA_W-1:0]    nxt_data;
   logic [NUM_BYTES-1:0] nxt_we;

   assign wsel = elem_w_e'(width_sel_i);

   pred_condition #(.PRED_W(PRED_W)) u_cond (
      .pred_raw (pred_i),
      .invert   (pred_inv_i),
      .pred_eff (pred_eff)
   );

   pred_expand #(.NUM_BYTES(NUM_BYTES)) u_expand (
      .width    (wsel),
      .pred_eff (pred_eff),
      .byte_act (byte_act)
   );

   lane_gate #(.NUM_BYTES(NUM_BYTES)) u_gate (
      .valid     (wr_valid_i),
      .zero_mode (zero_mode_i),
      .byte_act  (byte_act),
      .data_in   (data_i),
      .data_out  (nxt_data),
      .we_out    (nxt_we)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_data_o <= '0;
         byte_we_o <= '0;
      end else begin
         wr_data_o <= nxt_data;
         byte_we_o <= nxt_we;
      end
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      $past(rst) |-> (wr_data_o == '0 && byte_we_o == '0));

   // R9
   idle_no_enable_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr_valid_i)) |-> byte_we_o == '0);

   // R8
   zero_mode_all_we_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_valid_i) && $past(zero_mode_i)) |-> &byte_we_o);

   // R7 (and R2: one-cycle latency on data)
   merge_data_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_valid_i) && !$past(zero_mode_i))
      |-> wr_data_o == $past(data_i));

   // R4, R3
   byte_elem_we_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_valid_i) && !$past(zero_mode_i) && $past(width_sel_i) == 2'b00)
      |-> byte_we_o == ($past(pred_i) ^ {PRED_W{$past(pred_inv_i)}}));

   if (NUM_BYTES <= 8) begin : g_whole_word_chk
      // R6
      whole_word_we_chk: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(wr_valid_i) && !$past(zero_mode_i) && $past(width_sel_i) == 2'b11)
         |-> ($countones(byte_we_o) == 0 || $countones(byte_we_o) == NUM_BYTES));
   end

endmodule

// File: tb/wb_pred_masker_test.sv
`timescale 1ns/1ps
module wb_pred_masker_test;

   typedef struct {
      logic        chk_data;
      logic [63:0] data;
      logic [7:0]  we;
      int          cyc;
      string       tag;
   } exp_t;

   logic        clk = 0;
   logic        rst = 1;
   logic        wr_valid_i = 0;
   logic [63:0] data_i = '0;
   logic [1:0]  width_sel_i = '0;
   logic [7:0]  pred_i = '0;
   logic        pred_inv_i = 0;
   logic        zero_mode_i = 0;
   logic [63:0] wr_data_o;
   logic [7:0]  byte_we_o;

   int   n_run = 0;
   int   n_fail = 0;
   int   cyc = 0;
   bit   done = 0;
   exp_t sbq[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wb_pred_masker uut (
      .clk(clk), .rst(rst), .wr_valid_i(wr_valid_i), .data_i(data_i),
      .width_sel_i(width_sel_i), .pred_i(pred_i), .pred_inv_i(pred_inv_i),
      .zero_mode_i(zero_mode_i), .wr_data_o(wr_data_o), .byte_we_o(byte_we_o)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected outputs derived from R3..R9
   task automatic drive(input logic v, input logic [63:0] d, input logic [1:0] w,
                        input logic [7:0] p, input logic inv, input logic z, input string tag);
      exp_t e;
      logic [7:0] eff;
      eff = p ^ {8{inv}};
      e.chk_data = v;
      e.cyc = cyc;
      e.tag = tag;
      for (int b = 0; b < 8; b++) begin
         logic act;
         act = eff[b >> w];
         e.we[b] = v & (z | act);
         e.data[b*8 +: 8] = (z && !act) ? 8'h00 : d[b*8 +: 8];
      end
      wr_valid_i = v; data_i = d; width_sel_i = w; pred_i = p;
      pred_inv_i = inv; zero_mode_i = z;
      sbq.push_back(e);
      @(negedge clk);
   endtask

   // monitor: compare items one cycle after they were driven
   always @(negedge clk) begin
      if (sbq.size() > 0 && sbq[0].cyc < cyc) begin
         exp_t e;
         e = sbq.pop_front();
         check({e.tag, " we"}, {56'h0, byte_we_o}, {56'h0, e.we});
         if (e.chk_data) check({e.tag, " data"}, wr_data_o, e.data);
      end
   end

   initial begin
      #(8 * 200000);
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] lfsr;
      lfsr = 64'hACE1_2468_9BDF_1357;
      // R1: reset with busy inputs
      wr_valid_i = 1; data_i = '1; pred_i = '1; zero_mode_i = 1;
      repeat (3) @(negedge clk);
      check("R1 reset data", wr_data_o, 64'h0);
      check("R1 reset we", {56'h0, byte_we_o}, 64'h0);
      rst = 0;
      wr_valid_i = 0;
      // R4 R7 R2
      drive(1, 64'h0123_4567_89AB_CDEF, 2'b00, 8'hA5, 0, 0, "R4 merge w8 A5");
      drive(1, 64'hFEDC_BA98_7654_3210, 2'b00, 8'h3C, 0, 0, "R7 merge w8 3C");
      // R3
      drive(1, 64'h1111_2222_3333_4444, 2'b00, 8'hA5, 1, 0, "R3 invert w8");
      drive(1, 64'h1111_2222_3333_4444, 2'b01, 8'h05, 1, 1, "R3 invert zero w16");
      // R5
      drive(1, 64'hDEAD_BEEF_CAFE_F00D, 2'b01, 8'h09, 0, 0, "R5 merge w16");
      drive(1, 64'hDEAD_BEEF_CAFE_F00D, 2'b10, 8'h02, 0, 1, "R5 zero w32");
      drive(1, 64'hDEAD_BEEF_CAFE_F00D, 2'b11, 8'h01, 0, 0, "R5 merge w64");
      // R6
      drive(1, 64'h5555_AAAA_5555_AAAA, 2'b11, 8'hFE, 0, 0, "R6 w64 high bits ignored");
      drive(1, 64'h5555_AAAA_5555_AAAA, 2'b10, 8'hFC, 0, 1, "R6 w32 high bits ignored");
      drive(1, 64'h5555_AAAA_5555_AAAA, 2'b01, 8'hF5, 0, 0, "R6 w16 high bits ignored");
      // R8
      drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 8'h81, 0, 1, "R8 zero w8");
      drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 8'h00, 0, 1, "R8 zero all inactive");
      // R9
      drive(0, 64'h1234_5678_9ABC_DEF0, 2'b00, 8'hFF, 0, 1, "R9 idle zero mode");
      drive(0, 64'h1234_5678_9ABC_DEF0, 2'b11, 8'h00, 1, 0, "R9 idle merge inv");
      // R2: back-to-back mixed patterns
      for (int k = 0; k < 64; k++) begin
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         drive(lfsr[5], lfsr, lfsr[9:8], lfsr[23:16], lfsr[30], lfsr[41], "R2 stream");
      end
      drive(0, '0, 2'b00, 8'h00, 0, 0, "R9 drain");
      @(negedge clk);
      // R1: mid-run reset
      rst = 1;
      wr_valid_i = 1; zero_mode_i = 1; data_i = '1;
      @(negedge clk);
      check("R1 midrun data", wr_data_o, 64'h0);
      check("R1 midrun we", {56'h0, byte_we_o}, 64'h0);
      rst = 0;
      wr_valid_i = 0;
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule